// File: doc/BRIEF.md
# Byte-wide SPI serial port (master or slave)

This block is an 8-bit full-duplex synchronous serial port. It runs either as the clock master, when it makes the serial clock from the system clock, or as a slave, when it shifts on an external serial clock. Software reaches it through a small register port with three locations. A control register holds the enable, the clock idle level, the mode field and two sticky error flags. A status register holds the sample-point bit, the clock-edge bit and the buffer-full flag. A data location takes the byte to send when written and returns the last received byte when read.

Each write to the data location starts a transfer (master) or preloads the next outgoing byte (slave). After eight bits have moved, the received byte goes to the receive buffer, buffer-full is set and `byte_done` pulses for one cycle. `wake_req` repeats that pulse when `irq_en` is high. The `halt` input models low-power sleep. It freezes a master transfer in place, but a slave keeps shifting on the external clock, so a byte can arrive and raise a wake request while halted.

The register port has no valid/ready handshake and no back-pressure. Every access completes in the cycle it is presented. Data that cannot be taken is reported through the collision and overflow flags and is never stalled.

Top module: `spi_port`

## Requirements
- R1: After reset, the control register (address 0) and the status register (address 1) read 0x00, `sck_o` is low and `byte_done` is low.
- R2: `sck_o` idles at the control polarity bit (control bit 4). The edge bit (status bit 6) selects the phase. With edge=1, the first bit is on `sdo` before the first clock edge, data is sampled on the idle-to-active edge and changes on the active-to-idle edge. With edge=0, data changes on the idle-to-active edge and is sampled on the active-to-idle edge. Bits are sent and received MSB first.
- R3: Master mode is mode field (control bits 3:0) with bit 2 clear. Mode bits 1:0 equal to 0, 1 or 2 give a serial clock of the system clock divided by 4, 16 or 64, and 3 behaves like 2. The data write that starts a transfer is followed by `byte_done` exactly 8 × divisor cycles later.
- R4: The sample-point bit (status bit 7) makes the master sample `sdi` at the middle (0) or at the end (1) of each bit's output window. A slave that changes its output at the window boundary is received correctly in both settings.
- R5: In master mode, a data write (address 2) while enabled (control bit 5) and idle sends the byte on `sdo` and captures `sdi`. At completion the received byte is readable at address 2 and buffer-full (status bit 0) is 1.
- R6: `wake_req` pulses together with `byte_done` when `irq_en` is 1, and stays low when `irq_en` is 0.
- R7: While `halt` is high, a master transfer is frozen. Each halted cycle delays completion by one cycle and the bytes moved are unchanged.
- R8: Slave mode (mode bit 2 set) shifts only on `sck_i` edges, continues while `halt` is high, sends the byte last written to address 2, and completes after eight bits.
- R9: In slave mode, mode bit 0 = 0 honours `ss_n`. While `ss_n` is high, clock edges are ignored and the bit count restarts. Mode bit 0 = 1 ignores `ss_n`.
- R10: A data write while a byte is in progress sets the write-collision flag (control bit 7) and leaves the shifting byte unchanged.
- R11: A completion while buffer-full is already 1 sets the overflow flag (control bit 6) and discards the new byte, so the old byte stays readable.
- R12: Reading address 2 clears buffer-full. The collision and overflow flags clear only when a control write puts 0 in their bit; writing 1 leaves them as they are.
- R13: Clearing the enable aborts a transfer in progress. Data writes made while disabled start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, disables the port |
| halt | input | 1 | Low-power halt; freezes master shifting |
| irq_en | input | 1 | Allows completion to raise `wake_req` |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears buffer-full at address 2) |
| bus_addr | input | 2 | 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| byte_done | output | 1 | One-cycle pulse per completed byte |
| wake_req | output | 1 | Completion pulse gated by `irq_en` |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| ss_n | input | 1 | Active-low slave select |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench plays a slave against the master in all four clock modes and both sample points, and counts cycles from the starting write to completion. A wrong divider or a dropped half-period therefore shows up as a cycle count mismatch, and an inverted edge bit shows up as a shifted byte at one end or the other. It asserts `halt` in the middle of a master transfer. A design that keeps counting gives a short transfer, and one that loses state corrupts the byte. It then receives slave bytes while halted, with `ss_n` both honoured and ignored. A collision write during a transfer must leave the byte on the wire intact. A second unread byte must set overflow and leave the first byte readable. An abort by disabling must not leave a later transfer short.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int DW = 8;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic       wcol;
    logic       rov;
    logic       en;
    logic       cpol;
    logic [3:0] mode;
  } ctrl_t;
endpackage

// File: rtl/spi_mst_eng.sv
module spi_mst_eng #(
  parameter int RATE0 = 4,
  parameter int RATE1 = 16,
  parameter int RATE2 = 64,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         halt,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         smp,
  input  logic [1:0]   rate,
  input  logic         load,
  input  logic [W-1:0] load_byte,
  input  logic         sdi,
  output logic         sck,
  output logic         sdo,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_byte
);
  localparam int CW = $clog2(RATE2 / 2);
  localparam int BW = $clog2(W);

  logic [W-1:0]  sr;
  logic [CW-1:0] cnt, half_m1;
  logic [BW-1:0] bitc;
  logic          ph_b, samp, busy_q, tick;

  always_comb begin
    case (rate)
      2'd0:    half_m1 = CW'(RATE0 / 2 - 1);
      2'd1:    half_m1 = CW'(RATE1 / 2 - 1);
      default: half_m1 = CW'(RATE2 / 2 - 1);
    endcase
  end

  assign tick = busy_q && !halt && (cnt == half_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0; cnt <= '0; bitc <= '0; ph_b <= 1'b0;
      samp <= 1'b0; busy_q <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        busy_q <= 1'b0; cnt <= '0; ph_b <= 1'b0; bitc <= '0;
      end else if (load && !busy_q) begin
        sr <= load_byte; busy_q <= 1'b1; cnt <= '0; ph_b <= 1'b0; bitc <= '0;
      end else if (busy_q && !halt) begin
        if (!tick) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
          if (!ph_b) begin
            ph_b <= 1'b1;
            samp <= sdi;
          end else begin
            ph_b <= 1'b0;
            sr   <= {sr[W-2:0], smp ? sdi : samp};
            bitc <= bitc + 1'b1;
            if (bitc == BW'(W - 1)) begin
              busy_q <= 1'b0;
              done   <= 1'b1;
            end
          end
        end
      end
    end
  end

  // active half is the second one for phase 0, the first one for phase 1
  assign sck     = cpol ^ (busy_q & (cpha ? ~ph_b : ph_b));
  assign sdo     = sr[W-1];
  assign busy    = busy_q;
  assign rx_byte = sr;

  // R7: a halted transfer keeps its shift state and its timer
  p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && halt && en) |=> ($stable(sr) && $stable(cnt) && $stable(bitc)));

  // R13: dropping the enable ends any transfer
  p_disable_abort_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy_q);
endmodule

// File: rtl/spi_slv_eng.sv
module spi_slv_eng #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         use_ss,
  input  logic         sck_in,
  input  logic         ss_n,
  input  logic         sdi,
  input  logic         load,
  input  logic [W-1:0] load_byte,
  output logic         sdo,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_byte
);
  localparam int BW = $clog2(W);

  logic [2:0]    sck_sy;
  logic [1:0]    ss_sy;
  logic [W-1:0]  sr;
  logic [BW-1:0] bitc;
  logic          samp, edge_seen, lead, trail, selected;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0;
      ss_sy  <= '1;
    end else begin
      sck_sy <= {sck_sy[1:0], sck_in};
      ss_sy  <= {ss_sy[0], ss_n};
    end
  end

  assign edge_seen = sck_sy[1] ^ sck_sy[2];
  assign lead      = edge_seen && (sck_sy[1] != cpol);
  assign trail     = edge_seen && (sck_sy[1] == cpol);
  assign selected  = en && (!use_ss || !ss_sy[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0; bitc <= '0; samp <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (en && load && (bitc == '0)) begin
        sr <= load_byte;
      end else if (!selected) begin
        bitc <= '0;
      end else begin
        if (lead && !cpha) samp <= sdi;
        if (trail) begin
          sr   <= {sr[W-2:0], cpha ? sdi : samp};
          bitc <= bitc + 1'b1;
          if (bitc == BW'(W - 1)) done <= 1'b1;
        end
      end
    end
  end

  assign sdo     = sr[W-1];
  assign busy    = (bitc != '0);
  assign rx_byte = sr;

  // R8: a finished byte always leaves the bit counter back at zero
  p_slave_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: a deselected slave holds no partial byte
  p_deselect_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && use_ss && ss_sy[1] && !load) |=> !busy);
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int RATE0 = 4,
  parameter int RATE1 = 16,
  parameter int RATE2 = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt,
  input  logic       irq_en,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       byte_done,
  output logic       wake_req,
  output logic       sck_o,
  input  logic       sck_i,
  input  logic       ss_n,
  output logic       sdo,
  input  logic       sdi
);
  ctrl_t        ctrl_q;
  logic         smp_q, cke_q, bf_q;
  logic [DW-1:0] rxbuf_q, m_rx, s_rx;
  logic         is_slave, m_en, s_en, wr_ctrl, wr_stat, wr_data, rd_data;
  logic         active, load, m_busy, s_busy, m_done, s_done, done_any;
  logic         m_sdo, s_sdo;

  assign is_slave = ctrl_q.mode[2];
  assign m_en     = ctrl_q.en & ~is_slave;
  assign s_en     = ctrl_q.en & is_slave;
  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_stat  = bus_wr && (bus_addr == ADDR_STAT);
  assign wr_data  = bus_wr && (bus_addr == ADDR_DATA);
  assign rd_data  = bus_rd && (bus_addr == ADDR_DATA);
  assign active   = m_busy | s_busy;
  assign load     = wr_data && ctrl_q.en && !active;
  assign done_any = m_done | s_done;

  spi_mst_eng #(.RATE0(RATE0), .RATE1(RATE1), .RATE2(RATE2), .W(DW)) u_mst (
    .clk(clk), .rst_n(rst_n), .en(m_en), .halt(halt), .cpol(ctrl_q.cpol),
    .cpha(~cke_q), .smp(smp_q), .rate(ctrl_q.mode[1:0]), .load(load),
    .load_byte(bus_wdata), .sdi(sdi), .sck(sck_o), .sdo(m_sdo),
    .busy(m_busy), .done(m_done), .rx_byte(m_rx));

  spi_slv_eng #(.W(DW)) u_slv (
    .clk(clk), .rst_n(rst_n), .en(s_en), .cpol(ctrl_q.cpol), .cpha(~cke_q),
    .use_ss(~ctrl_q.mode[0]), .sck_in(sck_i), .ss_n(ss_n), .sdi(sdi),
    .load(load), .load_byte(bus_wdata), .sdo(s_sdo), .busy(s_busy),
    .done(s_done), .rx_byte(s_rx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      smp_q   <= 1'b0;
      cke_q   <= 1'b0;
      bf_q    <= 1'b0;
      rxbuf_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.wcol <= ctrl_q.wcol & bus_wdata[7];
        ctrl_q.rov  <= ctrl_q.rov & bus_wdata[6];
        ctrl_q.en   <= bus_wdata[5];
        ctrl_q.cpol <= bus_wdata[4];
        ctrl_q.mode <= bus_wdata[3:0];
      end
      if (wr_stat) begin
        smp_q <= bus_wdata[7];
        cke_q <= bus_wdata[6];
      end
      if (wr_data && ctrl_q.en && active) ctrl_q.wcol <= 1'b1;
      if (done_any) begin
        if (bf_q && !rd_data) begin
          ctrl_q.rov <= 1'b1;
        end else begin
          rxbuf_q <= is_slave ? s_rx : m_rx;
          bf_q    <= 1'b1;
        end
      end else if (rd_data) begin
        bf_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_CTRL: bus_rdata = ctrl_q;
      ADDR_STAT: bus_rdata = {smp_q, cke_q, 5'b0, bf_q};
      ADDR_DATA: bus_rdata = rxbuf_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign byte_done = done_any;
  assign wake_req  = done_any & irq_en;
  assign sdo       = is_slave ? s_sdo : m_sdo;

  // R10: a write that lands on a busy shifter raises the collision flag
  p_collision_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && ctrl_q.en && active) |=> ctrl_q.wcol);

  // R11: completion over an unread byte flags overflow and keeps the old byte
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_any && bf_q && !rd_data) |=> (ctrl_q.rov && $stable(rxbuf_q)));

  // R12: a data read with no completion empties the buffer
  p_read_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !done_any) |=> !bf_q);

  // R5: a completion always leaves the buffer full
  p_done_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_any |=> bf_q);
endmodule

// File: tb/test_spi_port.sv
`timescale 1ns/1ps
module test_spi_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt = 1'b0, irq_en = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       byte_done, wake_req, sck_o, sdo;
  logic       sck_i = 1'b0, ss_n = 1'b1, sdi_tb = 1'b0;

  int compared = 0, mismatched = 0;
  int done_cnt = 0, wake_cnt = 0;

  // bench slave model state
  logic       model_on = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0;
  logic [7:0] mbyte = 8'd0, cap = 8'd0;
  int         lc = 0, tc = 0;

  spi_port i_spi_port (
    .clk(clk), .rst_n(rst_n), .halt(halt), .irq_en(irq_en),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .byte_done(byte_done),
    .wake_req(wake_req), .sck_o(sck_o), .sck_i(sck_i), .ss_n(ss_n),
    .sdo(sdo), .sdi(sdi_tb));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (byte_done) done_cnt++;
    if (wake_req) wake_cnt++;
  end

  always @(sck_o) begin
    if (model_on) begin
      if (sck_o != m_cpol) begin
        if (!m_cpha) cap = {cap[6:0], sdo};
        else begin
          if (lc < 8) sdi_tb = mbyte[7 - lc];
          lc++;
        end
      end else begin
        if (!m_cpha) begin
          tc++;
          if (tc < 8) sdi_tb = mbyte[7 - tc];
        end else cap = {cap[6:0], sdo};
      end
    end
  end

  function automatic int div_of(input int r);
    return (r == 0) ? 4 : (r == 1) ? 16 : 64;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // master transfer against the bench slave model
  task automatic master_xfer(input logic cpol, input logic cke, input logic smp,
                             input int rate, input logic [7:0] tx,
                             input logic [7:0] rx, input int hc,
                             input logic coll, input string tag);
    int n;
    logic [7:0] rd;
    model_on = 1'b0;
    bus_write(2'd0, {2'b00, 1'b1, cpol, 2'b00, 2'(rate)});
    bus_write(2'd1, {smp, cke, 6'b0});
    m_cpol = cpol; m_cpha = ~cke; mbyte = rx; cap = 8'd0; lc = 0; tc = 0;
    sdi_tb = rx[7];
    model_on = 1'b1;
    check({tag, " R2 idle level"}, int'(sck_o), int'(cpol));
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = tx;
    @(posedge clk);
    n = 0;
    forever begin
      @(negedge clk);
      bus_wr = 1'b0;
      halt = (n >= 5) && (n < 5 + hc);
      if (coll && n == 10) begin
        bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = ~tx;
      end
      if (byte_done || n > 20000) break;
      @(posedge clk);
      n++;
    end
    check({tag, " R6 wake follows irq_en"}, int'(wake_req), int'(irq_en));
    halt = 1'b0; bus_wr = 1'b0;
    check({tag, " R3/R7 transfer cycles"}, n, 8 * div_of(rate) + hc);
    check({tag, " R5/R2/R10 byte sent"}, int'(cap), int'(tx));
    bus_read(2'd1, rd);
    check({tag, " R5 buffer full"}, int'(rd[0]), 1);
    bus_read(2'd2, rd);
    check({tag, " R4/R5 byte received"}, int'(rd), int'(rx));
    bus_read(2'd1, rd);
    check({tag, " R12 read clears full"}, int'(rd[0]), 0);
    model_on = 1'b0;
  endtask

  // bench acts as master, clocking the slave through sck_i
  task automatic slave_xfer(input logic cpol, input logic cke,
                            input logic [7:0] tx, output logic [7:0] got);
    got = 8'd0;
    if (cke) begin
      sdi_tb = tx[7];
      for (int i = 0; i < 8; i++) begin
        repeat (8) @(negedge clk);
        sck_i = ~cpol; got = {got[6:0], sdo};
        repeat (8) @(negedge clk);
        sck_i = cpol;
        if (i < 7) sdi_tb = tx[6 - i];
      end
    end else begin
      for (int i = 0; i < 8; i++) begin
        repeat (8) @(negedge clk);
        sck_i = ~cpol; sdi_tb = tx[7 - i];
        repeat (8) @(negedge clk);
        sck_i = cpol; got = {got[6:0], sdo};
      end
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic slave_setup(input logic cpol, input logic cke, input logic [3:0] mode);
    sck_i = cpol;
    repeat (6) @(negedge clk);
    bus_write(2'd0, {2'b00, 1'b1, cpol, mode});
    bus_write(2'd1, {1'b0, cke, 6'b0});
  endtask

  initial begin
    logic [7:0] rd, got, a_byte;
    int seed, d0, w0;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(2'd0, rd); check("R1 ctrl reset", int'(rd), 0);
    bus_read(2'd1, rd); check("R1 status reset", int'(rd), 0);
    check("R1 sck idle", int'(sck_o), 0);
    check("R1 no done", int'(byte_done), 0);

    // R13 disabled: data write starts nothing
    d0 = done_cnt;
    bus_write(2'd2, 8'h5A);
    repeat (300) @(negedge clk);
    check("R13 disabled no transfer", done_cnt - d0, 0);

    // directed master: each clock mode, both sample points, each rate
    irq_en = 1'b1;
    master_xfer(1'b0, 1'b1, 1'b0, 0, 8'hA5, 8'h3C, 0, 1'b0, "m00");
    master_xfer(1'b0, 1'b0, 1'b1, 1, 8'h81, 8'h7E, 0, 1'b0, "m01");
    master_xfer(1'b1, 1'b1, 1'b1, 2, 8'h01, 8'h80, 0, 1'b0, "m10");
    irq_en = 1'b0;
    w0 = wake_cnt;
    master_xfer(1'b1, 1'b0, 1'b0, 0, 8'hFF, 8'h00, 0, 1'b0, "m11");
    check("R6 no wake when masked", wake_cnt - w0, 0);
    master_xfer(1'b0, 1'b1, 1'b0, 3, 8'h96, 8'h69, 0, 1'b0, "rate3");

    // R7 halt mid transfer
    master_xfer(1'b0, 1'b0, 1'b0, 0, 8'hC3, 8'h5A, 7, 1'b0, "halt");

    // R10 collision write during a transfer
    master_xfer(1'b1, 1'b1, 1'b0, 1, 8'h4D, 8'hB2, 0, 1'b1, "coll");
    bus_read(2'd0, rd); check("R10 wcol set", int'(rd[7]), 1);
    bus_write(2'd0, {rd[7:6], rd[5:0]});
    bus_read(2'd0, rd); check("R12 writing 1 keeps wcol", int'(rd[7]), 1);
    bus_write(2'd0, {1'b0, rd[6:0]});
    bus_read(2'd0, rd); check("R12 writing 0 clears wcol", int'(rd[7]), 0);

    // R13 abort by disabling, then a full-length transfer follows
    d0 = done_cnt;
    bus_write(2'd0, 8'h22);
    bus_write(2'd2, 8'hEE);
    repeat (40) @(negedge clk);
    bus_write(2'd0, 8'h02);
    repeat (600) @(negedge clk);
    check("R13 abort no completion", done_cnt - d0, 0);
    master_xfer(1'b0, 1'b1, 1'b0, 2, 8'h37, 8'hC8, 0, 1'b0, "after_abort");

    // random master transfers
    for (int k = 0; k < 20; k++) begin
      master_xfer(1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(0, 2),
                  8'($urandom), 8'($urandom), $urandom_range(0, 12), 1'b0, "rand");
    end

    // R8 slave, ss ignored, receiving while halted
    irq_en = 1'b1;
    slave_setup(1'b0, 1'b1, 4'b0101);
    bus_write(2'd2, 8'hD4);
    halt = 1'b1;
    d0 = done_cnt; w0 = wake_cnt;
    slave_xfer(1'b0, 1'b1, 8'h2B, got);
    halt = 1'b0;
    check("R8 slave done in halt", done_cnt - d0, 1);
    check("R6/R8 wake in halt", wake_cnt - w0, 1);
    check("R8 slave sent", int'(got), 8'hD4);
    bus_read(2'd2, rd); check("R8 slave received", int'(rd), 8'h2B);

    // R8 slave, other phase and polarity
    slave_setup(1'b1, 1'b0, 4'b0101);
    bus_write(2'd2, 8'h9E);
    slave_xfer(1'b1, 1'b0, 8'h61, got);
    check("R8 slave cpha1 sent", int'(got), 8'h9E);
    bus_read(2'd2, rd); check("R8 slave cpha1 received", int'(rd), 8'h61);

    // R9 ss honoured: deselected slave ignores clocks
    slave_setup(1'b0, 1'b1, 4'b0100);
    ss_n = 1'b1;
    d0 = done_cnt;
    slave_xfer(1'b0, 1'b1, 8'hF0, got);
    check("R9 deselected ignores sck", done_cnt - d0, 0);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    bus_write(2'd2, 8'h3A);
    slave_xfer(1'b0, 1'b1, 8'hC5, got);
    check("R9 selected done", done_cnt - d0, 1);
    check("R9 selected sent", int'(got), 8'h3A);
    bus_read(2'd2, a_byte); check("R9 selected received", int'(a_byte), 8'hC5);
    ss_n = 1'b1;

    // R11 overflow: two bytes with no read between
    slave_setup(1'b0, 1'b1, 4'b0101);
    slave_xfer(1'b0, 1'b1, 8'h11, got);
    slave_xfer(1'b0, 1'b1, 8'h22, got);
    bus_read(2'd0, rd); check("R11 overflow flag", int'(rd[6]), 1);
    bus_read(2'd2, rd); check("R11 old byte kept", int'(rd), 8'h11);
    bus_read(2'd0, rd);
    bus_write(2'd0, rd);
    bus_read(2'd0, rd); check("R12 writing 1 keeps rov", int'(rd[6]), 1);
    bus_write(2'd0, {rd[7], 1'b0, rd[5:0]});
    bus_read(2'd0, rd); check("R12 writing 0 clears rov", int'(rd[6]), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule